// File: doc/BRIEF.md
# Spare-Sector Probe Sequencer

When a track develops a secondary defect, a replacement has to be found in the spare slot (physical sector 32 of the 33 on a track; only 32 are addressable) of some other track. This block produces the order in which cylinders and heads are probed for an unused, good spare. It emits one probe per strobe and takes a found or not-found verdict for the current probe back on the same strobe. Reading the spare slot and rewriting ID fields belong to other logic.

In movable-head mode the search starts on the defect's own cylinder and tries each head there in ascending order. It then fans outward to the cylinder one above, one below, two above, two below, and so on. An offset that would leave the cylinder range 0 to 358 is skipped, so near a limit the search continues only away from it. In fixed-head mode the eight fixed-head tracks come first. The search then falls back to cylinder 0, with movable heads numbered from 1, and climbs one cylinder at a time. A hit freezes the presented probe until the next restart. Running out of cylinders raises an exhausted flag.

Top module: `spare_probe_seq`

## Requirements
- R1: After reset, `probe_valid_o`, `found_o`, `exhausted_o` and `probe_fixed_o` are 0, and `probe_cyl_o` and `probe_head_o` are 0.
- R2: A high `start_i` at a clock edge restarts the search in the next cycle with `probe_valid_o`, `found_o` and `exhausted_o` all 0. The first `next_i` after that presents the first probe. Every output change shows one cycle after the strobe that caused it.
- R3: In movable-head mode (`fixed_mode_i` = 0), the first probes are on the start cylinder with heads 0 to MOV_HEADS-1 in ascending order. Each later cylinder is also probed on heads 0 to MOV_HEADS-1 in ascending order.
- R4: After the start cylinder S, the cylinders follow S+1, S-1, S+2, S-2, S+3, ... in that order.
- R5: A cylinder outside 0 to CYL_LAST (default 358) is skipped without a probe. Once one side is out of range, only the other side is visited, one step further each time.
- R6: In fixed-head mode (`fixed_mode_i` = 1), the first FIX_HEADS probes (default 8) present `probe_fixed_o` = 1, `probe_cyl_o` = 0 and heads 0, 1, ... FIX_HEADS-1 in order. The start cylinder is ignored.
- R7: After the fixed heads in fixed-head mode, probes present `probe_fixed_o` = 0 on cylinder 0 with heads 1 to MOV_HEADS, then on cylinders 1, 2, ... in ascending order with the same heads.
- R8: `next_i` with `hit_i` = 1 while a probe is presented sets `found_o`. From then on all probe outputs hold, `probe_valid_o` stays 1, and further `next_i` or `hit_i` pulses have no effect until `start_i`. `hit_i` is only sampled together with `next_i`.
- R9: `next_i` with `hit_i` = 0 on the last possible probe sets `exhausted_o` and clears `probe_valid_o`. Both stay that way under further `next_i` until `start_i`.
- R10: A start cylinder above CYL_LAST is treated as CYL_LAST.
- R11: `start_i` takes effect in any state, including after found or exhausted, and clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Restart the search |
| fixed_mode_i | input | 1 | 1 = fixed-head search, 0 = movable-head search (sampled with start_i) |
| start_cyl_i | input | 9 | Cylinder of the defect (sampled with start_i) |
| next_i | input | 1 | Strobe: present the first probe, or judge the current one and move on |
| hit_i | input | 1 | Verdict on the current probe, sampled with next_i (1 = free spare found) |
| probe_valid_o | output | 1 | A probe is presented |
| probe_cyl_o | output | 9 | Cylinder of the presented probe |
| probe_head_o | output | 3 | Head of the presented probe |
| probe_fixed_o | output | 1 | The presented head is a fixed head |
| found_o | output | 1 | A free spare was found; outputs frozen |
| exhausted_o | output | 1 | Every cylinder was probed without success |

## Verification
The hardest state to reach is exhaustion. It needs more than 700 consecutive failed probes, with the far side of the fan-out crossing a cylinder limit on the way. The bench drives complete sweeps from start cylinders 0, 180, 357 and 358, and a full fixed-head sweep. It compares every probe against its own model of the order, which ranks cylinders by distance, upper side first. Each sweep ends on the exhausted flag. A hand-written table also pins the bounce points next to both limits.

// File: rtl/spare_seq_pkg.sv
package spare_seq_pkg;

    localparam int DEF_CYL_LAST  = 358;
    localparam int DEF_MOV_HEADS = 2;
    localparam int DEF_FIX_HEADS = 8;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FIXED,
        SQ_MOVE,
        SQ_FOUND,
        SQ_EXHAUST
    } seq_state_e;

    // Number of distinct head codes the output has to carry.
    function automatic int head_span(input int fix_heads, input int mov_heads);
        return (fix_heads > mov_heads + 1) ? fix_heads : mov_heads + 1;
    endfunction

    function automatic int width_for(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/spare_cyl_fan.sv
// Next cylinder of the outward fan-out around a centre cylinder.
// minus_last_i = 1 means the previous cylinder was centre-dist (or the centre).
module spare_cyl_fan #(
    parameter int CYL_W    = 9,
    parameter int CYL_LAST = 358
) (
    input  logic [CYL_W-1:0] center_i,
    input  logic [CYL_W-1:0] dist_i,
    input  logic             minus_last_i,
    output logic [CYL_W-1:0] cyl_o,
    output logic [CYL_W-1:0] dist_o,
    output logic             minus_o,
    output logic             done_o
);
    localparam int EXT_W = CYL_W + 1;
    localparam logic [EXT_W-1:0] LAST_X = EXT_W'(CYL_LAST);

    logic [CYL_W-1:0] dist_up;
    logic [EXT_W-1:0] up_x;
    logic             up_ok, dn_same_ok, dn_next_ok;

    assign dist_up    = dist_i + 1'b1;
    assign up_x       = {1'b0, center_i} + {1'b0, dist_up};
    assign up_ok      = (up_x <= LAST_X);
    assign dn_same_ok = (center_i >= dist_i);
    assign dn_next_ok = (center_i >= dist_up);

    always_comb begin
        cyl_o   = center_i;
        dist_o  = dist_i;
        minus_o = minus_last_i;
        done_o  = 1'b0;
        if (!minus_last_i && dn_same_ok) begin
            cyl_o   = center_i - dist_i;
            minus_o = 1'b1;
        end else if (up_ok) begin
            cyl_o   = center_i + dist_up;
            dist_o  = dist_up;
            minus_o = 1'b0;
        end else if (minus_last_i && dn_next_ok) begin
            cyl_o   = center_i - dist_up;
            dist_o  = dist_up;
            minus_o = 1'b1;
        end else begin
            done_o  = 1'b1;
        end
    end
endmodule

// File: rtl/spare_head_step.sv
// Ascending head walk within one cylinder or within the fixed-head set.
module spare_head_step #(
    parameter int HEAD_W = 3
) (
    input  logic [HEAD_W-1:0] head_i,
    input  logic [HEAD_W-1:0] last_i,
    output logic              at_last_o,
    output logic [HEAD_W-1:0] head_o
);
    assign at_last_o = (head_i == last_i);
    assign head_o    = head_i + 1'b1;
endmodule

// File: rtl/spare_probe_seq.sv
module spare_probe_seq
    import spare_seq_pkg::*;
#(
    parameter int CYL_LAST  = DEF_CYL_LAST,
    parameter int MOV_HEADS = DEF_MOV_HEADS,
    parameter int FIX_HEADS = DEF_FIX_HEADS,
    localparam int CYL_W    = width_for(CYL_LAST + 1),
    localparam int HEAD_W   = width_for(head_span(FIX_HEADS, MOV_HEADS))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              fixed_mode_i,
    input  logic [CYL_W-1:0]  start_cyl_i,
    input  logic              next_i,
    input  logic              hit_i,
    output logic              probe_valid_o,
    output logic [CYL_W-1:0]  probe_cyl_o,
    output logic [HEAD_W-1:0] probe_head_o,
    output logic              probe_fixed_o,
    output logic              found_o,
    output logic              exhausted_o
);
    localparam logic [CYL_W-1:0]  LAST_CYL  = CYL_W'(CYL_LAST);
    localparam logic [HEAD_W-1:0] FIX_LAST  = HEAD_W'(FIX_HEADS - 1);
    localparam logic [HEAD_W-1:0] MOV_LAST0 = HEAD_W'(MOV_HEADS - 1);

    seq_state_e        state_q;
    logic              valid_q, fixed_q, minus_q, base_q;
    logic [CYL_W-1:0]  cyl_q, center_q, dist_q;
    logic [HEAD_W-1:0] head_q;

    logic [CYL_W-1:0]  start_cyl;
    logic [CYL_W-1:0]  fan_cyl, fan_dist;
    logic              fan_minus, fan_done;
    logic [HEAD_W-1:0] head_last, head_inc, head_base;
    logic              head_wrap;

    assign start_cyl = (start_cyl_i > LAST_CYL) ? LAST_CYL : start_cyl_i;
    assign head_base = {{(HEAD_W-1){1'b0}}, base_q};
    assign head_last = (state_q == SQ_FIXED) ? FIX_LAST : (MOV_LAST0 + head_base);

    spare_cyl_fan #(
        .CYL_W    (CYL_W),
        .CYL_LAST (CYL_LAST)
    ) u_fan (
        .center_i     (center_q),
        .dist_i       (dist_q),
        .minus_last_i (minus_q),
        .cyl_o        (fan_cyl),
        .dist_o       (fan_dist),
        .minus_o      (fan_minus),
        .done_o       (fan_done)
    );

    spare_head_step #(
        .HEAD_W (HEAD_W)
    ) u_head (
        .head_i    (head_q),
        .last_i    (head_last),
        .at_last_o (head_wrap),
        .head_o    (head_inc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            valid_q  <= 1'b0;
            fixed_q  <= 1'b0;
            minus_q  <= 1'b1;
            base_q   <= 1'b0;
            cyl_q    <= '0;
            center_q <= '0;
            dist_q   <= '0;
            head_q   <= '0;
        end else if (start_i) begin
            state_q  <= fixed_mode_i ? SQ_FIXED : SQ_MOVE;
            valid_q  <= 1'b0;
            fixed_q  <= fixed_mode_i;
            minus_q  <= 1'b1;
            base_q   <= 1'b0;
            center_q <= start_cyl;
            cyl_q    <= fixed_mode_i ? '0 : start_cyl;
            dist_q   <= '0;
            head_q   <= '0;
        end else if (next_i && (state_q == SQ_FIXED || state_q == SQ_MOVE)) begin
            if (!valid_q) begin
                valid_q <= 1'b1;
            end else if (hit_i) begin
                state_q <= SQ_FOUND;
            end else if (!head_wrap) begin
                head_q <= head_inc;
            end else if (state_q == SQ_FIXED) begin
                // Fixed heads used up: fall back to cylinder 0, movable heads from 1.
                state_q  <= SQ_MOVE;
                fixed_q  <= 1'b0;
                base_q   <= 1'b1;
                center_q <= '0;
                cyl_q    <= '0;
                dist_q   <= '0;
                minus_q  <= 1'b1;
                head_q   <= HEAD_W'(1);
            end else if (fan_done) begin
                state_q <= SQ_EXHAUST;
                valid_q <= 1'b0;
            end else begin
                cyl_q   <= fan_cyl;
                dist_q  <= fan_dist;
                minus_q <= fan_minus;
                head_q  <= head_base;
            end
        end
    end

    assign probe_valid_o = valid_q;
    assign probe_cyl_o   = cyl_q;
    assign probe_head_o  = head_q;
    assign probe_fixed_o = fixed_q;
    assign found_o       = (state_q == SQ_FOUND);
    assign exhausted_o   = (state_q == SQ_EXHAUST);
endmodule

// File: rtl/spare_probe_seq_chk.sv
module spare_probe_seq_chk #(
    parameter int CYL_LAST  = 358,
    parameter int MOV_HEADS = 2,
    parameter int CYL_W     = 9,
    parameter int HEAD_W    = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              next_i,
    input logic              probe_valid_o,
    input logic [CYL_W-1:0]  probe_cyl_o,
    input logic [HEAD_W-1:0] probe_head_o,
    input logic              probe_fixed_o,
    input logic              found_o,
    input logic              exhausted_o
);
    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!probe_valid_o && !found_o && !exhausted_o));

    a_r2_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !next_i) |=> ($stable(probe_cyl_o) && $stable(probe_head_o)
                                   && $stable(probe_valid_o)));

    a_r5_cyl_in_range: assert property (@(posedge clk) disable iff (rst)
        probe_valid_o |-> (probe_cyl_o <= CYL_W'(CYL_LAST)));

    a_r3_head_in_range: assert property (@(posedge clk) disable iff (rst)
        (probe_valid_o && !probe_fixed_o) |-> (probe_head_o <= HEAD_W'(MOV_HEADS)));

    a_r6_fixed_on_cyl0: assert property (@(posedge clk) disable iff (rst)
        probe_fixed_o |-> (probe_cyl_o == '0));

    a_r8_found_freeze: assert property (@(posedge clk) disable iff (rst)
        (found_o && !start_i) |=> (found_o && probe_valid_o && $stable(probe_cyl_o)
                                   && $stable(probe_head_o) && $stable(probe_fixed_o)));

    a_r9_exhaust_hold: assert property (@(posedge clk) disable iff (rst)
        (exhausted_o && !start_i) |=> (exhausted_o && !probe_valid_o));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({found_o, exhausted_o}));
endmodule

bind spare_probe_seq spare_probe_seq_chk #(
    .CYL_LAST  (CYL_LAST),
    .MOV_HEADS (MOV_HEADS),
    .CYL_W     (CYL_W),
    .HEAD_W    (HEAD_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .next_i        (next_i),
    .probe_valid_o (probe_valid_o),
    .probe_cyl_o   (probe_cyl_o),
    .probe_head_o  (probe_head_o),
    .probe_fixed_o (probe_fixed_o),
    .found_o       (found_o),
    .exhausted_o   (exhausted_o)
);

// File: tb/tb_spare_probe_seq.sv
module tb_spare_probe_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LAST = 358;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0, fixed_mode_i = 1'b0, next_i = 1'b0, hit_i = 1'b0;
    logic [8:0] start_cyl_i = '0;
    logic       probe_valid_o, probe_fixed_o, found_o, exhausted_o;
    logic [8:0] probe_cyl_o;
    logic [2:0] probe_head_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spare_probe_seq dut (
        .clk(clk), .rst(rst), .start_i(start_i), .fixed_mode_i(fixed_mode_i),
        .start_cyl_i(start_cyl_i), .next_i(next_i), .hit_i(hit_i),
        .probe_valid_o(probe_valid_o), .probe_cyl_o(probe_cyl_o),
        .probe_head_o(probe_head_o), .probe_fixed_o(probe_fixed_o),
        .found_o(found_o), .exhausted_o(exhausted_o)
    );

    typedef struct packed {
        logic       fx;
        logic [8:0] start;
        logic [9:0] n;
        logic [8:0] cyl;
        logic [2:0] head;
        logic       fixed;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 9'd100, 10'd0,  9'd100, 3'd0, 1'b0},  // R3
        '{1'b0, 9'd100, 10'd1,  9'd100, 3'd1, 1'b0},  // R3
        '{1'b0, 9'd100, 10'd2,  9'd101, 3'd0, 1'b0},  // R4
        '{1'b0, 9'd100, 10'd4,  9'd99,  3'd0, 1'b0},  // R4
        '{1'b0, 9'd100, 10'd6,  9'd102, 3'd0, 1'b0},  // R4
        '{1'b0, 9'd100, 10'd9,  9'd98,  3'd1, 1'b0},  // R4
        '{1'b0, 9'd0,   10'd2,  9'd1,   3'd0, 1'b0},  // R5
        '{1'b0, 9'd0,   10'd4,  9'd2,   3'd0, 1'b0},  // R5
        '{1'b0, 9'd358, 10'd2,  9'd357, 3'd0, 1'b0},  // R5
        '{1'b0, 9'd358, 10'd5,  9'd356, 3'd1, 1'b0},  // R5
        '{1'b0, 9'd357, 10'd2,  9'd358, 3'd0, 1'b0},  // R5
        '{1'b0, 9'd357, 10'd4,  9'd356, 3'd0, 1'b0},  // R5
        '{1'b0, 9'd357, 10'd6,  9'd355, 3'd0, 1'b0},  // R5
        '{1'b0, 9'd1,   10'd4,  9'd0,   3'd0, 1'b0},  // R5
        '{1'b0, 9'd1,   10'd6,  9'd3,   3'd0, 1'b0},  // R5
        '{1'b0, 9'd400, 10'd0,  9'd358, 3'd0, 1'b0},  // R10
        '{1'b1, 9'd50,  10'd0,  9'd0,   3'd0, 1'b1},  // R6
        '{1'b1, 9'd50,  10'd7,  9'd0,   3'd7, 1'b1},  // R6
        '{1'b1, 9'd50,  10'd8,  9'd0,   3'd1, 1'b0},  // R7
        '{1'b1, 9'd50,  10'd9,  9'd0,   3'd2, 1'b0},  // R7
        '{1'b1, 9'd50,  10'd10, 9'd1,   3'd1, 1'b0},  // R7
        '{1'b1, 9'd50,  10'd13, 9'd2,   3'd2, 1'b0}   // R7
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_start(input bit fx, input int cyl);
        @(negedge clk);
        start_i = 1'b1; fixed_mode_i = fx; start_cyl_i = cyl[8:0];
        @(negedge clk);
        start_i = 1'b0; fixed_mode_i = 1'b0;
    endtask

    task automatic pulse_next(input bit hit);
        @(negedge clk);
        next_i = 1'b1; hit_i = hit;
        @(negedge clk);
        next_i = 1'b0; hit_i = 1'b0;
    endtask

    // Independent model of the n-th probe (n = 0 is the first).
    task automatic model(input bit fx, input int start, input int n,
                         output int cyl, output int head, output bit fixed, output bit exh);
        int s, j, cnt;
        cyl = 0; head = 0; fixed = 0; exh = 1;
        s = (start > LAST) ? LAST : start;
        if (fx) begin
            if (n < 8) begin
                fixed = 1; head = n; exh = 0;
            end else begin
                cyl = (n - 8) / 2; head = 1 + (n - 8) % 2;
                exh = (cyl > LAST);
            end
            return;
        end
        j = n / 2; head = n % 2; cnt = 0;
        for (int d = 0; d <= LAST; d++) begin
            for (int side = 0; side < 2; side++) begin
                int c;
                if (d == 0 && side == 1) continue;
                c = (side == 0) ? s + d : s - d;
                if (c < 0 || c > LAST) continue;
                if (cnt == j) begin cyl = c; exh = 0; return; end
                cnt++;
            end
        end
    endtask

    task automatic sweep(input bit fx, input int start, input string req);
        int ec, eh; bit ef, ex;
        do_start(fx, start);
        for (int n = 0; n < 800; n++) begin
            pulse_next(1'b0);
            model(fx, start, n, ec, eh, ef, ex);
            if (ex) begin
                check(exhausted_o && !probe_valid_o, "R9", {exhausted_o, probe_valid_o}, 2);
                break;
            end
            check(probe_valid_o && probe_cyl_o == ec && probe_head_o == eh && probe_fixed_o == ef,
                  req, {probe_valid_o, probe_fixed_o, probe_cyl_o, probe_head_o},
                  {1'b1, ef, ec[8:0], eh[2:0]});
        end
        pulse_next(1'b0);
        pulse_next(1'b1);
        check(exhausted_o && !probe_valid_o && !found_o, "R9",
              {found_o, exhausted_o, probe_valid_o}, 3'b010);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(!probe_valid_o && !found_o && !exhausted_o && !probe_fixed_o
              && probe_cyl_o == 0 && probe_head_o == 0, "R1",
              {probe_valid_o, found_o, exhausted_o, probe_fixed_o, probe_cyl_o, probe_head_o}, 0);

        // R2: no probe until the first strobe
        do_start(1'b0, 200);
        check(!probe_valid_o && !found_o && !exhausted_o, "R2", probe_valid_o, 0);
        pulse_next(1'b0);
        check(probe_valid_o && probe_cyl_o == 200 && probe_head_o == 0, "R2",
              {probe_valid_o, probe_cyl_o}, {1'b1, 9'd200});

        // Table walk
        for (int v = 0; v < NV; v++) begin
            do_start(VEC[v].fx, int'(VEC[v].start));
            for (int k = 0; k <= int'(VEC[v].n); k++) pulse_next(1'b0);
            check(probe_valid_o && probe_cyl_o == VEC[v].cyl && probe_head_o == VEC[v].head
                  && probe_fixed_o == VEC[v].fixed,
                  VEC[v].fx ? (VEC[v].fixed ? "R6" : "R7") : "R3/R4/R5/R10 vector",
                  {probe_fixed_o, probe_cyl_o, probe_head_o},
                  {VEC[v].fixed, VEC[v].cyl, VEC[v].head});
        end

        // R8: hit freezes the presented probe (n=3 -> cylinder 101 head 1)
        do_start(1'b0, 100);
        for (int k = 0; k < 4; k++) pulse_next(1'b0);
        pulse_next(1'b1);
        check(found_o && probe_valid_o && probe_cyl_o == 101 && probe_head_o == 1, "R8",
              {found_o, probe_cyl_o, probe_head_o}, {1'b1, 9'd101, 3'd1});
        pulse_next(1'b0);
        pulse_next(1'b1);
        @(negedge clk); hit_i = 1'b1; @(negedge clk); hit_i = 1'b0;
        check(found_o && probe_valid_o && probe_cyl_o == 101 && probe_head_o == 1, "R8",
              {found_o, probe_cyl_o, probe_head_o}, {1'b1, 9'd101, 3'd1});

        // R8: hit_i without next_i is ignored
        do_start(1'b0, 10);
        pulse_next(1'b0);
        @(negedge clk); hit_i = 1'b1; @(negedge clk); hit_i = 1'b0;
        check(!found_o && probe_cyl_o == 10 && probe_head_o == 0, "R8",
              {found_o, probe_cyl_o}, {1'b0, 9'd10});

        // R11: restart from found
        pulse_next(1'b1);
        check(found_o, "R8", found_o, 1);
        do_start(1'b1, 0);
        check(!found_o && !exhausted_o && !probe_valid_o, "R11",
              {found_o, exhausted_o, probe_valid_o}, 0);

        // Full sweeps to exhaustion
        sweep(1'b0, 0,   "R5");
        sweep(1'b0, 358, "R5");
        sweep(1'b0, 180, "R4");
        sweep(1'b0, 357, "R5");
        sweep(1'b1, 0,   "R7");

        // R11: restart from exhausted
        do_start(1'b0, 5);
        check(!exhausted_o && !probe_valid_o, "R11", {exhausted_o, probe_valid_o}, 0);
        pulse_next(1'b0);
        check(probe_valid_o && probe_cyl_o == 5, "R11", probe_cyl_o, 5);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule